// File: doc/BRIEF.md
# Bus-Phase Rising-Edge Delay and Work-RAM Gate

This block sits between the console CPU bus and the cartridge work-RAM, which occupies $6000-$7FFF. The CPU's phase-two bus clock (M2) marks the part of each cycle in which an access is valid. The address and read/write lines are still settling just after M2 goes high, so a RAM that is opened at that rising edge can pick up stray writes. The block samples raw M2 with a fast free-running clock. It produces a shaped M2 whose rising edge is held back by a fixed number of fast-clock cycles. Its falling edge follows raw M2 straight away, through logic only and with no register on the path.

The shaped phase gates the RAM chip-enable and write-enable. The ROM select line from the console is active low. It is not delayed, and its high level stands in for CPU A15 being low. Because that line lags M2 by tens of nanoseconds, the RAM strobes are ended by the M2 falling edge and never by the select line. The mapper supplies one enable bit that can lock the RAM out completely.

After a reset the block waits until it has seen M2 low. This keeps it from opening the RAM partway through a phase that was already running.

Top module: `bus_phase_gate`

## Requirements
- R1: While reset is high, and after reset for any M2 high phase that began before M2 was first sampled low, m2_shaped stays 0 and ram_ce_n and ram_we_n stay 1.
- R2: When m2_raw rises, m2_shaped rises at the SYNC_STAGES+DELAY_CYCLES-th rising fast-clock edge after it (6 with the defaults 2 and 4). It does not rise earlier.
- R3: m2_shaped falls at the same instant as m2_raw falls, with no fast-clock edge in between.
- R4: An M2 high phase that lasts fewer than SYNC_STAGES+DELAY_CYCLES fast-clock edges produces no m2_shaped pulse and no RAM strobe.
- R5: ram_ce_n is 0 exactly when m2_shaped=1, romsel_n=1, cpu_a14=1, cpu_a13=1 and ram_en=1. In every other case it is 1.
- R6: ram_we_n is 0 exactly when ram_ce_n is 0 and cpu_rw_n is 0 (0 means write). During reads it stays 1.
- R7: romsel_n is not delayed. A change on it during an open phase reaches ram_ce_n without waiting for a fast-clock edge.
- R8: At the M2 falling edge, ram_ce_n and ram_we_n go to 1 at once, even if romsel_n is still 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast free-running oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| m2_raw | input | 1 | Raw CPU phase-two bus clock |
| romsel_n | input | 1 | Undelayed ROM select, active low; high means A15 low |
| cpu_a14 | input | 1 | CPU address bit 14 |
| cpu_a13 | input | 1 | CPU address bit 13 |
| cpu_rw_n | input | 1 | CPU read/write, 1 read, 0 write |
| ram_en | input | 1 | Mapper work-RAM enable bit |
| m2_shaped | output | 1 | M2 with delayed rise and immediate fall |
| ram_ce_n | output | 1 | Work-RAM chip enable, active low |
| ram_we_n | output | 1 | Work-RAM write enable, active low |

## Verification
Two events can land in the same instant: the M2 falling edge, and the select line still reading high because it lags M2. On a correct design the falling edge closes the strobes at once. The bench holds romsel_n high across every M2 fall and samples the strobes one time step after the fall, before any fast-clock edge. It runs this for all 32 combinations of select, address, direction and enable, and each time requires both strobes to be inactive. The same sweep checks the decode during the open phase against values computed in the bench, and checks that the rising-edge latency is exactly the expected count.

// File: rtl/phase_gate_pkg.sv
package phase_gate_pkg;

    typedef enum logic [1:0] {
        PH_UNARMED = 2'd0,
        PH_LOW     = 2'd1,
        PH_COUNT   = 2'd2,
        PH_OPEN    = 2'd3
    } phase_state_t;

    typedef struct packed {
        logic romsel_n;
        logic a14;
        logic a13;
        logic rw_n;
        logic ram_en;
    } bus_view_t;

    typedef struct packed {
        logic ce_n;
        logic we_n;
    } ram_strobe_t;

    // work-RAM window: A15 low (select high), A14 and A13 high, mapper enable set
    function automatic logic window_hit(input bus_view_t b);
        return b.romsel_n & b.a14 & b.a13 & b.ram_en;
    endfunction

endpackage

// File: rtl/phase_sync.sv
module phase_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    // preset high so a phase in progress at reset is not mistaken for a new one
                    if (rst) chain_q[i] <= 1'b1;
                    else     chain_q[i] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b1;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/rise_delay.sv
module rise_delay
    import phase_gate_pkg::*;
#(
    parameter int DELAY_CYCLES = 4,
    localparam int CNT_W = (DELAY_CYCLES < 2) ? 1 : $clog2(DELAY_CYCLES)
) (
    input  logic clk,
    input  logic rst,
    input  logic m2_sync,
    output logic open_q
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYCLES - 1);

    phase_state_t      state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!m2_sync) begin
            state_d = PH_LOW;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                PH_UNARMED: state_d = PH_UNARMED;
                PH_LOW: begin
                    cnt_d   = '0;
                    state_d = (DELAY_CYCLES == 1) ? PH_OPEN : PH_COUNT;
                end
                PH_COUNT: begin
                    if (cnt_q == LAST - CNT_W'(1)) state_d = PH_OPEN;
                    else                           cnt_d   = cnt_q + CNT_W'(1);
                end
                PH_OPEN: state_d = PH_OPEN;
                default: state_d = PH_UNARMED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_UNARMED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign open_q = (state_q == PH_OPEN);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST); // R2
    AST_RESET_CLOSED: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !open_q); // R1
    AST_CLOSE_ON_LOW: assert property (@(posedge clk) disable iff (rst)
        !m2_sync |=> !open_q); // R4
    AST_OPEN_AFTER_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(open_q) |-> $past(m2_sync)); // R2
endmodule

// File: rtl/ram_decode.sv
module ram_decode
    import phase_gate_pkg::*;
(
    input  logic        phase_on,
    input  bus_view_t   bus,
    output ram_strobe_t strobe
);
    logic sel;

    always_comb begin
        sel         = phase_on & window_hit(bus);
        strobe.ce_n = ~sel;
        strobe.we_n = ~(sel & ~bus.rw_n);
    end
endmodule

// File: rtl/bus_phase_gate.sv
module bus_phase_gate
    import phase_gate_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int DELAY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic m2_raw,
    input  logic romsel_n,
    input  logic cpu_a14,
    input  logic cpu_a13,
    input  logic cpu_rw_n,
    input  logic ram_en,
    output logic m2_shaped,
    output logic ram_ce_n,
    output logic ram_we_n
);
    logic        m2_sync;
    logic        open_q;
    bus_view_t   bus;
    ram_strobe_t strobe;

    phase_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (m2_raw),
        .q_out (m2_sync)
    );

    rise_delay #(.DELAY_CYCLES(DELAY_CYCLES)) u_delay (
        .clk     (clk),
        .rst     (rst),
        .m2_sync (m2_sync),
        .open_q  (open_q)
    );

    // falling edge passes through logic only; the rise waits for the registered flag
    assign m2_shaped = m2_raw & open_q;

    always_comb begin
        bus.romsel_n = romsel_n;
        bus.a14      = cpu_a14;
        bus.a13      = cpu_a13;
        bus.rw_n     = cpu_rw_n;
        bus.ram_en   = ram_en;
    end

    ram_decode u_decode (
        .phase_on (m2_shaped),
        .bus      (bus),
        .strobe   (strobe)
    );

    assign ram_ce_n = strobe.ce_n;
    assign ram_we_n = strobe.we_n;

    AST_WE_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
        cpu_rw_n |-> ram_we_n); // R6
    AST_CE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
        !ram_ce_n |-> romsel_n); // R5
    AST_STROBE_NEEDS_OPEN: assert property (@(posedge clk) disable iff (rst)
        !ram_ce_n |-> (open_q && m2_raw)); // R8
    AST_SHAPED_AFTER_SYNC: assert property (@(posedge clk) disable iff (rst)
        m2_shaped |-> $past(m2_sync)); // R2
endmodule

// File: tb/test_bus_phase_gate.sv
module test_bus_phase_gate;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC_STAGES = 2;
    localparam int DELAY_CYCLES = 4;
    localparam int LAT = SYNC_STAGES + DELAY_CYCLES;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m2_raw = 1'b0;
    logic romsel_n = 1'b1, cpu_a14 = 1'b0, cpu_a13 = 1'b0, cpu_rw_n = 1'b1, ram_en = 1'b0;
    logic m2_shaped, ram_ce_n, ram_we_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_phase_gate #(.SYNC_STAGES(SYNC_STAGES), .DELAY_CYCLES(DELAY_CYCLES)) i_bus_phase_gate (
        .clk(clk), .rst(rst), .m2_raw(m2_raw), .romsel_n(romsel_n),
        .cpu_a14(cpu_a14), .cpu_a13(cpu_a13), .cpu_rw_n(cpu_rw_n), .ram_en(ram_en),
        .m2_shaped(m2_shaped), .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_bus(input int code);
        romsel_n = code[0]; cpu_a14 = code[1]; cpu_a13 = code[2];
        cpu_rw_n = code[3]; ram_en = code[4];
    endtask

    // one M2 cycle: high for hi_edges fast edges, then low; romsel_n left as set (still high at the fall)
    task automatic run_phase(input int hi_edges, input logic hit, input logic wr);
        @(negedge clk);
        m2_raw = 1'b1;
        #1 chk("R2 no rise at M2 edge", m2_shaped, 1'b0);
        for (int k = 1; k <= hi_edges; k++) begin
            @(posedge clk);
            #1;
            if (hi_edges < LAT) begin
                chk("R4 short phase shaped", m2_shaped, 1'b0);
                chk("R4 short phase ce", ram_ce_n, 1'b1);
            end else begin
                chk("R2 rise latency", m2_shaped, (k >= LAT));
                if (k >= LAT) begin
                    chk("R5 ce decode", ram_ce_n, ~hit);
                    chk("R6 we decode", ram_we_n, ~(hit & wr));
                end else begin
                    chk("R2 ce before open", ram_ce_n, 1'b1);
                end
            end
        end
        @(negedge clk);
        m2_raw = 1'b0;
        #1;
        chk("R3 immediate fall", m2_shaped, 1'b0);
        chk("R8 ce released at fall", ram_ce_n, 1'b1);
        chk("R8 we released at fall", ram_we_n, 1'b1);
        repeat (SYNC_STAGES + 2) @(posedge clk);
        #1 chk("R3 stays low", m2_shaped, 1'b0);
    endtask

    initial begin
        // R1: M2 already high during and after reset
        set_bus(5'b10111);           // window hit, write
        m2_raw = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset shaped", m2_shaped, 1'b0);
        chk("R1 reset ce", ram_ce_n, 1'b1);
        chk("R1 reset we", ram_we_n, 1'b1);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < LAT + 6; k++) begin
            @(posedge clk);
            #1;
            chk("R1 unarmed shaped", m2_shaped, 1'b0);
            chk("R1 unarmed we", ram_we_n, 1'b1);
        end
        @(negedge clk);
        m2_raw = 1'b0;
        repeat (SYNC_STAGES + 2) @(posedge clk);

        // full sweep of bus combinations with a long phase
        for (int c = 0; c < 32; c++) begin
            logic hit, wr;
            @(negedge clk);
            set_bus(c);
            hit = c[0] & c[1] & c[2] & c[4];
            wr  = ~c[3];
            run_phase(LAT + 4, hit, wr);
        end

        // short phases of every length below the latency
        set_bus(5'b10111);
        for (int h = 1; h < LAT; h++) run_phase(h, 1'b1, 1'b1);

        // exact-latency phase: open for one edge
        run_phase(LAT, 1'b1, 1'b1);

        // R7: select toggled mid-phase reaches ce without a clock edge
        @(negedge clk);
        m2_raw = 1'b1;
        repeat (LAT + 1) @(posedge clk);
        #1 chk("R7 open before toggle", ram_ce_n, 1'b0);
        #2 romsel_n = 1'b0;
        #1 chk("R7 select low closes ce", ram_ce_n, 1'b1);
        chk("R7 select low closes we", ram_we_n, 1'b1);
        romsel_n = 1'b1;
        #1 chk("R7 select high reopens ce", ram_ce_n, 1'b0);
        @(negedge clk);
        m2_raw = 1'b0;
        #1 chk("R8 fall with select high", ram_ce_n, 1'b1);
        repeat (4) @(posedge clk);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule